// File: doc/BRIEF.md
# Multidrop Serial Character Receiver

This block recovers asynchronous serial characters from a single input line. It oversamples the line on an external tick enable and confirms each start bit at its midpoint. It then collects 7, 8 or 9 data bits, least significant first. In the 7- and 8-bit formats it can check an optional parity bit. Each character ends with a stop-bit check. A finished character goes into a receive buffer and a buffer-full flag is raised, which the host clears by pulsing a buffer-read strobe.

Parity, framing and overrun problems are each kept in a sticky flag, and an overall error output reports when any of them is set. A status-read strobe clears the three sticky flags. A line-gap indicator rises on a framing error and stays up until the line returns high. For multidrop networks, an attention bit set by the host makes the receiver drop every 9-bit character whose ninth bit is 0. The first character with the ninth bit set is accepted and turns the attention bit off. One character-length code takes the line from a local transmitter output instead of the external pin.

Top module: `mrx_uart_rx`

## Requirements
- R1: After reset, buf_full, err_parity, err_frame, err_overrun, err_any, rx_gap, attn and rx_bit9 are all 0.
- R2: The cfg_len code sets the number of data bits: 00 gives 8, 01 gives 7, 10 gives 9. Bits are received least significant first and right-justified in rx_data, and unused upper bits read 0. An accepted character sets buf_full.
- R3: A start bit counts only if the line is still low at mid-bit. With 16 ticks per bit, a low pulse shorter than half a bit is ignored and leaves buf_full unchanged.
- R4: When cfg_par_en is 1 and the format is 7 or 8 bits, one parity bit follows the data. cfg_par_sel picks the expected value: 00 odd, 01 even, 10 always 1, 11 always 0. A mismatch sets err_parity. The 9-bit formats carry no parity bit.
- R5: A low stop-bit sample sets err_frame and rx_gap. rx_gap clears once the line is high again.
- R6: If a character is accepted while buf_full is still 1 and no buffer read happens in that cycle, err_overrun is set and the new character replaces the buffer contents.
- R7: A one-cycle rd_buf pulse clears buf_full.
- R8: err_parity, err_frame and err_overrun stay set until a rd_stat pulse clears them. An error event in the same cycle as the pulse takes priority.
- R9: err_any is 1 exactly when at least one of err_parity, err_frame and err_overrun is 1.
- R10: In the 9-bit formats, rx_bit9 holds the ninth bit of the last accepted character. In the 7- and 8-bit formats it reads 0.
- R11: attn_wr loads attn from attn_wdata. In the 9-bit formats, while attn is 1, a character with ninth bit 0 is dropped: the buffer, buf_full and the sticky flags do not change. A character with ninth bit 1 is accepted and clears attn.
- R12: With cfg_len = 11 the receiver samples txd_loop instead of rxd and uses the 9-bit format. The level on rxd has no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Oversampling enable, 16 per bit time |
| rxd | input | 1 | External serial input |
| txd_loop | input | 1 | Local transmitter output used in loopback |
| cfg_len | input | 2 | Character-length code |
| cfg_par_en | input | 1 | Parity enable (7/8-bit formats) |
| cfg_par_sel | input | 2 | Parity kind select |
| attn_wr | input | 1 | Write strobe for the attention bit |
| attn_wdata | input | 1 | Value written to the attention bit |
| rd_buf | input | 1 | Receive buffer read strobe |
| rd_stat | input | 1 | Status read strobe, clears sticky errors |
| rx_data | output | 9 | Receive buffer |
| buf_full | output | 1 | Buffer holds an unread character |
| err_any | output | 1 | Overall error indicator |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| rx_gap | output | 1 | Line held low after a framing error |
| attn | output | 1 | Attention mode active |
| rx_bit9 | output | 1 | Ninth bit of the last accepted character |

## Verification
The line passes through a two-stage synchronizer. The frame engine registers a completion pulse at the tick that samples the stop bit, and the buffer and flags update on the next edge. Buffer, flag and ninth-bit results are therefore due about four clocks after that tick, which falls at the middle of the stop bit. The bench holds each bit for 32 clocks and compares results only after the stop bit and a further idle bit have passed. It checks the line-gap indicator while the line is still held low and again two bit times after the line returns high. Strobe effects are due one edge after the strobe, so the bench samples them at the following falling edge.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

    localparam int MAX_BITS = 9;
    localparam int IDX_W    = $clog2(MAX_BITS);

    typedef enum logic [1:0] {
        LEN_8    = 2'b00,
        LEN_7    = 2'b01,
        LEN_9    = 2'b10,
        LEN_LOOP = 2'b11
    } len_e;

    typedef enum logic [1:0] {
        PAR_ODD   = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_MARK  = 2'b10,
        PAR_SPACE = 2'b11
    } par_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_BREAK
    } rx_st_e;

    // index of the last data bit for a length code
    function automatic logic [IDX_W-1:0] last_idx(input logic [1:0] len);
        case (len_e'(len))
            LEN_7:   last_idx = IDX_W'(6);
            LEN_8:   last_idx = IDX_W'(7);
            default: last_idx = IDX_W'(MAX_BITS - 1);
        endcase
    endfunction

    function automatic logic is_nine(input logic [1:0] len);
        is_nine = len[1];
    endfunction

endpackage

// File: rtl/mrx_line_sel.sv
module mrx_line_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       txd_loop,
    input  logic [1:0] cfg_len,
    output logic       line
);
    import mrx_pkg::*;

    logic raw;
    assign raw = (len_e'(cfg_len) == LEN_LOOP) ? txd_loop : rxd;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign line = raw;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] sync_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '1;
                end else begin
                    sync_q[0] <= raw;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        sync_q[i] <= sync_q[i-1];
                    end
                end
            end
            assign line = sync_q[SYNC_STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/mrx_parity.sv
module mrx_parity (
    input  logic [mrx_pkg::MAX_BITS-1:0] data,
    input  logic [1:0]                   cfg_len,
    input  logic                         cfg_par_en,
    input  logic [1:0]                   cfg_par_sel,
    input  logic                         par_bit,
    output logic                         par_active,
    output logic                         par_err
);
    import mrx_pkg::*;

    logic ones;
    logic want;

    always_comb begin
        par_active = cfg_par_en && !is_nine(cfg_len);
        ones       = ^data;
        case (par_e'(cfg_par_sel))
            PAR_ODD:   want = ~ones;
            PAR_EVEN:  want = ones;
            PAR_MARK:  want = 1'b1;
            default:   want = 1'b0;
        endcase
        par_err = par_active && (par_bit != want);
    end
endmodule

// File: rtl/mrx_frame.sv
module mrx_frame #(
    parameter int OVS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick,
    input  logic                         line,
    input  logic [1:0]                   cfg_len,
    input  logic                         par_active,
    output logic                         done,
    output logic [mrx_pkg::MAX_BITS-1:0] data,
    output logic                         par_bit,
    output logic                         stop_ok
);
    import mrx_pkg::*;

    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2 - 1;

    typedef struct packed {
        rx_st_e               st;
        logic [CW-1:0]        cnt;
        logic [IDX_W-1:0]     idx;
        logic [MAX_BITS-1:0]  shf;
        logic                 par;
        logic                 stop;
        logic                 done;
    } frm_t;

    frm_t fr_q, fr_d;

    always_comb begin
        fr_d      = fr_q;
        fr_d.done = 1'b0;
        case (fr_q.st)
            ST_IDLE: begin
                if (tick && !line) begin
                    fr_d.st  = ST_START;
                    fr_d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (fr_q.cnt == CW'(MID)) begin
                        fr_d.cnt = '0;
                        fr_d.idx = '0;
                        fr_d.shf = '0;
                        fr_d.st  = line ? ST_IDLE : ST_DATA;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (fr_q.cnt == CW'(OVS - 1)) begin
                        fr_d.cnt          = '0;
                        fr_d.shf[fr_q.idx] = line;
                        if (fr_q.idx == last_idx(cfg_len)) begin
                            fr_d.st = par_active ? ST_PAR : ST_STOP;
                        end else begin
                            fr_d.idx = fr_q.idx + 1'b1;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (fr_q.cnt == CW'(OVS - 1)) begin
                        fr_d.cnt = '0;
                        fr_d.par = line;
                        fr_d.st  = ST_STOP;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (fr_q.cnt == CW'(OVS - 1)) begin
                        fr_d.cnt  = '0;
                        fr_d.stop = line;
                        fr_d.done = 1'b1;
                        fr_d.st   = line ? ST_IDLE : ST_BREAK;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
            end
            ST_BREAK: begin
                if (line) begin
                    fr_d.st = ST_IDLE;
                end
            end
            default: fr_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q <= '{st: ST_IDLE, stop: 1'b1, default: '0};
        end else begin
            fr_q <= fr_d;
        end
    end

    assign done    = fr_q.done;
    assign data    = fr_q.shf;
    assign par_bit = fr_q.par;
    assign stop_ok = fr_q.stop;
endmodule

// File: rtl/mrx_flags.sv
module mrx_flags (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         done,
    input  logic [mrx_pkg::MAX_BITS-1:0] data,
    input  logic                         stop_ok,
    input  logic                         par_err,
    input  logic [1:0]                   cfg_len,
    input  logic                         line,
    input  logic                         attn_wr,
    input  logic                         attn_wdata,
    input  logic                         rd_buf,
    input  logic                         rd_stat,
    output logic [mrx_pkg::MAX_BITS-1:0] rx_data,
    output logic                         buf_full,
    output logic                         err_parity,
    output logic                         err_frame,
    output logic                         err_overrun,
    output logic                         rx_gap,
    output logic                         attn,
    output logic                         rx_bit9
);
    import mrx_pkg::*;

    typedef struct packed {
        logic [MAX_BITS-1:0] buf_data;
        logic                full;
        logic                pe;
        logic                fe;
        logic                doe;
        logic                gap;
        logic                attn;
        logic                bit9;
    } flg_t;

    flg_t fl_q, fl_d;

    logic nine, top_bit, discard, accept;

    always_comb begin
        nine    = is_nine(cfg_len);
        top_bit = data[MAX_BITS-1];
        discard = fl_q.attn && nine && !top_bit;
        accept  = done && !discard;

        fl_d = fl_q;

        if (rd_buf) fl_d.full = 1'b0;
        if (rd_stat) begin
            fl_d.pe  = 1'b0;
            fl_d.fe  = 1'b0;
            fl_d.doe = 1'b0;
        end

        if (accept) begin
            fl_d.buf_data = data;
            fl_d.bit9     = nine && top_bit;
            fl_d.full     = 1'b1;
            if (par_err)           fl_d.pe  = 1'b1;
            if (!stop_ok)          fl_d.fe  = 1'b1;
            if (fl_q.full && !rd_buf) fl_d.doe = 1'b1;
        end

        if (done && !stop_ok) begin
            fl_d.gap = 1'b1;
        end else if (line) begin
            fl_d.gap = 1'b0;
        end

        if (attn_wr) fl_d.attn = attn_wdata;
        if (done && nine && top_bit) fl_d.attn = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign rx_data     = fl_q.buf_data;
    assign buf_full    = fl_q.full;
    assign err_parity  = fl_q.pe;
    assign err_frame   = fl_q.fe;
    assign err_overrun = fl_q.doe;
    assign rx_gap      = fl_q.gap;
    assign attn        = fl_q.attn;
    assign rx_bit9     = fl_q.bit9;
endmodule

// File: rtl/mrx_uart_rx.sv
module mrx_uart_rx #(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic       txd_loop,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic [1:0] cfg_par_sel,
    input  logic       attn_wr,
    input  logic       attn_wdata,
    input  logic       rd_buf,
    input  logic       rd_stat,
    output logic [8:0] rx_data,
    output logic       buf_full,
    output logic       err_any,
    output logic       err_parity,
    output logic       err_frame,
    output logic       err_overrun,
    output logic       rx_gap,
    output logic       attn,
    output logic       rx_bit9
);
    import mrx_pkg::*;

    logic                line_s;
    logic                par_active;
    logic                par_err;
    logic                frm_done;
    logic [MAX_BITS-1:0] frm_data;
    logic                frm_par;
    logic                frm_stop;

    mrx_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd      (rxd),
        .txd_loop (txd_loop),
        .cfg_len  (cfg_len),
        .line     (line_s)
    );

    mrx_frame #(.OVS(OVS)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .line       (line_s),
        .cfg_len    (cfg_len),
        .par_active (par_active),
        .done       (frm_done),
        .data       (frm_data),
        .par_bit    (frm_par),
        .stop_ok    (frm_stop)
    );

    mrx_parity u_par (
        .data        (frm_data),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_sel (cfg_par_sel),
        .par_bit     (frm_par),
        .par_active  (par_active),
        .par_err     (par_err)
    );

    mrx_flags u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .done        (frm_done),
        .data        (frm_data),
        .stop_ok     (frm_stop),
        .par_err     (par_err),
        .cfg_len     (cfg_len),
        .line        (line_s),
        .attn_wr     (attn_wr),
        .attn_wdata  (attn_wdata),
        .rd_buf      (rd_buf),
        .rd_stat     (rd_stat),
        .rx_data     (rx_data),
        .buf_full    (buf_full),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun),
        .rx_gap      (rx_gap),
        .attn        (attn),
        .rx_bit9     (rx_bit9)
    );

    assign err_any = err_parity | err_frame | err_overrun;
endmodule

// File: rtl/mrx_uart_rx_chk.sv
module mrx_uart_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_buf,
    input logic       rd_stat,
    input logic       line,
    input logic       done,
    input logic       nine,
    input logic       bit9,
    input logic       attn,
    input logic       buf_full,
    input logic [8:0] rx_data,
    input logic       err_parity,
    input logic       err_frame,
    input logic       err_overrun,
    input logic       rx_gap
);
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(rx_data)); // R2

    AST_RD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_buf && !done) |=> !buf_full); // R7

    AST_STICKY_PE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity && !rd_stat) |=> err_parity); // R8

    AST_STICKY_FE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame && !rd_stat) |=> err_frame); // R8

    AST_STICKY_OV: assert property (@(posedge clk) disable iff (!rst_n)
        (err_overrun && !rd_stat) |=> err_overrun); // R8

    AST_GAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (line && !done) |=> !rx_gap); // R5

    AST_ATTN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && attn && nine && !bit9 && !buf_full && !rd_buf) |=> !buf_full); // R11

    AST_ATTN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done && nine && bit9) |=> !attn); // R11
endmodule

bind mrx_uart_rx mrx_uart_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_buf      (rd_buf),
    .rd_stat     (rd_stat),
    .line        (line_s),
    .done        (frm_done),
    .nine        (cfg_len[1]),
    .bit9        (frm_data[8]),
    .attn        (attn),
    .buf_full    (buf_full),
    .rx_data     (rx_data),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun),
    .rx_gap      (rx_gap)
);

// File: tb/tb_mrx_uart_rx.sv
`timescale 1ns/100ps
module tb_mrx_uart_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rxd = 1'b1;
    logic       txd_loop = 1'b1;
    logic [1:0] cfg_len = 2'b00;
    logic       cfg_par_en = 1'b0;
    logic [1:0] cfg_par_sel = 2'b00;
    logic       attn_wr = 1'b0;
    logic       attn_wdata = 1'b0;
    logic       rd_buf = 1'b0;
    logic       rd_stat = 1'b0;
    logic [8:0] rx_data;
    logic       buf_full, err_any, err_parity, err_frame, err_overrun;
    logic       rx_gap, attn, rx_bit9;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    // bench model
    logic [8:0] m_buf = '0;
    bit m_full = 0, m_pe = 0, m_fe = 0, m_doe = 0, m_attn = 0, m_bit9 = 0;

    localparam int BIT_CLKS = 32; // 16 ticks, one tick every 2 clocks

    always #2.5 clk = ~clk;
    always @(negedge clk) tick <= ~tick;

    mrx_uart_rx dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .txd_loop(txd_loop),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_sel(cfg_par_sel),
        .attn_wr(attn_wr), .attn_wdata(attn_wdata), .rd_buf(rd_buf), .rd_stat(rd_stat),
        .rx_data(rx_data), .buf_full(buf_full), .err_any(err_any),
        .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
        .rx_gap(rx_gap), .attn(attn), .rx_bit9(rx_bit9)
    );

    task automatic chk(input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    function automatic int nbits(input logic [1:0] len);
        return (len == 2'b01) ? 7 : (len == 2'b00) ? 8 : 9;
    endfunction

    function automatic logic [8:0] mask_data(input logic [8:0] d, input logic [1:0] len);
        return d & ((9'h1 << nbits(len)) - 9'h1);
    endfunction

    function automatic logic want_par(input logic [8:0] d, input logic [1:0] sel);
        case (sel)
            2'b00:   return ~(^d);
            2'b01:   return ^d;
            2'b10:   return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic put(input logic b);
        if (cfg_len == 2'b11) begin
            txd_loop = b;
            rxd = 1'b0; // must be ignored in loopback (R12)
        end else begin
            rxd = b;
        end
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " R2 rx_data"}, rx_data, m_buf);
        chk({tag, " R2 buf_full"}, buf_full, m_full);
        chk({tag, " R4 err_parity"}, err_parity, m_pe);
        chk({tag, " R5 err_frame"}, err_frame, m_fe);
        chk({tag, " R6 err_overrun"}, err_overrun, m_doe);
        chk({tag, " R9 err_any"}, err_any, m_pe | m_fe | m_doe);
        chk({tag, " R11 attn"}, attn, m_attn);
        chk({tag, " R10 rx_bit9"}, rx_bit9, m_bit9);
    endtask

    task automatic send_frame(input logic [8:0] d_in, input bit flip, input bit bad_stop,
                              input string tag);
        logic [8:0] d;
        bit pact, nine, discard;
        d = mask_data(d_in, cfg_len);
        nine = cfg_len[1];
        pact = cfg_par_en && !nine;
        put(1'b0);
        for (int i = 0; i < nbits(cfg_len); i++) put(d[i]);
        if (pact) put(want_par(d, cfg_par_sel) ^ flip);
        put(bad_stop ? 1'b0 : 1'b1);
        if (bad_stop) begin
            put(1'b0);
            chk({tag, " R5 rx_gap high while line low"}, rx_gap, 1);
            put(1'b1);
        end
        put(1'b1);
        rxd = 1'b1;
        txd_loop = 1'b1;
        repeat (4) @(negedge clk);
        chk({tag, " R5 rx_gap after line high"}, rx_gap, 0);
        discard = m_attn && nine && !d[8];
        if (!discard) begin
            if (m_full) m_doe = 1;
            m_buf = d;
            m_full = 1;
            if (pact && flip) m_pe = 1;
            if (bad_stop) m_fe = 1;
            m_bit9 = nine && d[8];
        end
        if (nine && d[8]) m_attn = 0;
        compare_all(tag);
    endtask

    task automatic read_buf();
        @(negedge clk) rd_buf = 1'b1;
        @(negedge clk) rd_buf = 1'b0;
        m_full = 0;
        chk("R7 buf_full after read", buf_full, 0);
    endtask

    task automatic read_stat();
        @(negedge clk) rd_stat = 1'b1;
        chk("R8 err_frame visible at read", err_frame, m_fe);
        chk("R8 err_parity visible at read", err_parity, m_pe);
        @(negedge clk) rd_stat = 1'b0;
        m_pe = 0; m_fe = 0; m_doe = 0;
        chk("R8 err_parity cleared", err_parity, 0);
        chk("R8 err_frame cleared", err_frame, 0);
        chk("R8 err_overrun cleared", err_overrun, 0);
        chk("R9 err_any cleared", err_any, 0);
    endtask

    task automatic write_attn(input bit v);
        @(negedge clk) begin attn_wr = 1'b1; attn_wdata = v; end
        @(negedge clk) attn_wr = 1'b0;
        m_attn = v;
        chk("R11 attn written", attn, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 buf_full", buf_full, 0);
        chk("R1 err_any", err_any, 0);
        chk("R1 rx_gap", rx_gap, 0);
        chk("R1 attn", attn, 0);
        chk("R1 rx_bit9", rx_bit9, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 flags after release", {err_parity, err_frame, err_overrun}, 0);

        // R2 8-bit character
        cfg_len = 2'b00;
        send_frame(9'h0A5, 0, 0, "R2 8bit");
        read_buf();

        // R3 short glitch ignored
        rxd = 1'b0;
        repeat (8) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R3 glitch ignored buf_full", buf_full, 0);
        chk("R3 glitch ignored err_frame", err_frame, 0);

        // R6 overrun
        send_frame(9'h011, 0, 0, "R6 first");
        send_frame(9'h0EE, 0, 0, "R6 second");
        chk("R6 overrun data replaced", rx_data, 9'h0EE);
        read_buf();
        read_stat();

        // R4 7-bit parity modes
        cfg_len = 2'b01; cfg_par_en = 1'b1;
        for (int s = 0; s < 4; s++) begin
            cfg_par_sel = 2'(s);
            send_frame(9'h05B, 0, 0, "R4 good");
            chk("R4 no parity error", err_parity, 0);
            send_frame(9'h05B, 1, 0, "R4 flipped");
            chk("R4 parity error seen", err_parity, 1);
            read_buf();
            read_stat();
        end
        cfg_par_en = 1'b0;

        // R5 framing error
        cfg_len = 2'b00;
        send_frame(9'h03C, 0, 1, "R5 bad stop");
        read_buf();
        read_stat();

        // R10 / R11 nine-bit and attention
        cfg_len = 2'b10;
        send_frame(9'h155, 0, 0, "R10 bit9 set");
        chk("R10 rx_bit9", rx_bit9, 1);
        read_buf();
        write_attn(1);
        send_frame(9'h033, 0, 0, "R11 dropped");
        chk("R11 dropped keeps buffer empty", buf_full, 0);
        send_frame(9'h1C4, 0, 0, "R11 address");
        chk("R11 address accepted", rx_data, 9'h1C4);
        chk("R11 attn cleared", attn, 0);
        read_buf();

        // R12 loopback, rxd forced low during frame
        cfg_len = 2'b11;
        send_frame(9'h0A6, 0, 0, "R12 loop");
        chk("R12 loop data", rx_data, 9'h0A6);
        read_buf();

        // constrained random
        for (int n = 0; n < 110; n++) begin
            bit flip, bad;
            logic [8:0] d;
            cfg_len     = 2'($urandom % 4);
            cfg_par_en  = 1'($urandom % 2);
            cfg_par_sel = 2'($urandom % 4);
            d = 9'($urandom);
            flip = cfg_par_en && !cfg_len[1] && ($urandom % 4 == 0);
            bad  = ($urandom % 8 == 0);
            if (cfg_len[1] && ($urandom % 5 == 0)) write_attn(1);
            send_frame(d, flip, bad, "RND");
            if ($urandom % 2 == 0) read_buf();
            if ($urandom % 3 == 0) read_stat();
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule